// File: doc/BRIEF.md
# Debounced Wake-Up Input Controller

This block sits in the always-on slow-clock domain and decides when the core supply must be restarted. It watches a bank of external wake pins and three internal event sources: a calendar alarm, a timer alarm and a supply-monitor output. Each pin is resynchronized, then qualified by its own enable bit and its own active-level bit. The qualified pins are ORed into one trigger. A single shared counter debounces that trigger, and its period comes from a small fixed table. The three internal sources each have an enable bit and bypass the debounce counter.

When a wake event occurs, the block raises a level wake request that stays high until an acknowledge pulse. In the same cycle it snapshots the synchronized pin levels into a status register, which software reads to identify the source. A later wake event replaces the snapshot. Reading the status register clears it. Configuration uses a plain strobe-based register port with combinational read data.

Top module: `wake_debounce_ctrl`

## Requirements
- R1: After reset, wakeReq is 0 and the pin configuration, mode and status registers all read as 0.
- R2: Address 0 holds the pin enables in bits [15:0] and the active-level bits in [31:16]. Address 1 holds the debounce select in bits [2:0] and source enables in [10:8] (bit 8 calendar alarm, bit 9 timer alarm, bit 10 supply monitor). Both read back what was written, with unused bits reading 0. Address 3 reads 0.
- R3: A pin counts as active only when its enable bit is 1 and its synchronized level equals its active-level bit (1 = high active, 0 = low active). A disabled pin has no effect on wakeReq.
- R4: The debounce select maps 0,1,2,3,4,5 to periods of 0,3,32,512,4096,32768 slow-clock cycles. Selects 6 and 7 use 32768.
- R5: With period P, a debounced wake fires only when the combined trigger has been high for P+1 consecutive cycles. wakeReq rises on the (P+3)-th clock edge after the pin change, counting two synchronizer stages and the request register.
- R6: Whenever the trigger drops before the wake fires, the debounce count clears to zero, so a new assertion restarts counting from zero.
- R7: With select 0, a single cycle of active trigger is enough for a wake.
- R8: On every wake event, the status register (address 2, bits [NPIN-1:0]) captures the synchronized pin levels. A read of address 2 clears it, and a capture in the same cycle as the read takes priority over the clear.
- R9: A later wake event overwrites the status captured by an earlier one.
- R10: A rising edge of an enabled internal source raises wakeReq at the next clock edge without debouncing. Disabled sources are ignored.
- R11: wakeReq stays high until a wakeAck cycle clears it. A wake event in the same cycle as wakeAck keeps it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wakePins | input | NPIN | External wake pins (asynchronous) |
| calAlarm | input | 1 | Calendar alarm event source |
| tmrAlarm | input | 1 | Timer alarm event source |
| supMon | input | 1 | Supply-monitor event source |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (clears status on address 2) |
| regAddr | input | 2 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Combinational register read data |
| wakeAck | input | 1 | Acknowledge, clears wakeReq |
| wakeReq | output | 1 | Core-supply restart request (level) |

## Verification
The hardest case to reach is a status read that falls in the same cycle as a wake capture. To hit it, the bench waits exactly two synchronizer edges after driving an immediate-mode pin, then places the read strobe in the cycle where the capture lands. It then checks that the snapshot survives. The exact firing boundary is another narrow case. The bench drives pulses that are exactly P and P+1 cycles long, and cuts a pulse for a single cycle partway through, to show that the count clears. It also walks the longest period through an out-of-range select encoding.

// File: rtl/wake_ctrl_pkg.sv
package wake_ctrl_pkg;
  localparam int LONGEST_PERIOD = 32768;
  localparam int CNT_W = $clog2(LONGEST_PERIOD + 2);
  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    ADDR_PINCFG = 2'd0,
    ADDR_MODE   = 2'd1,
    ADDR_STATUS = 2'd2,
    ADDR_RSVD   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic wrPinCfg;
    logic wrMode;
    logic clrStatus;
    logic capStatus;
  } strobe_t;

  function automatic logic [CNT_W-1:0] debounce_period(input logic [2:0] sel);
    logic [CNT_W-1:0] p;
    case (sel)
      3'd0:    p = CNT_W'(0);
      3'd1:    p = CNT_W'(3);
      3'd2:    p = CNT_W'(32);
      3'd3:    p = CNT_W'(512);
      3'd4:    p = CNT_W'(4096);
      default: p = CNT_W'(LONGEST_PERIOD);
    endcase
    return p;
  endfunction
endpackage

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_ctrl_pkg::*;
#(
  parameter int NPIN = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPIN-1:0]  pinsIn,
  input  logic [NSRC-1:0]  srcIn,
  input  strobe_t          strb,
  input  logic [31:0]      wdata,
  input  logic [1:0]       rdAddr,
  output logic [31:0]      rdData,
  output logic             trigger,
  output logic [CNT_W-1:0] dbCount,
  output logic             dbFire,
  output logic             alarmEvt,
  output logic [NPIN-1:0]  pinSync,
  output logic [NPIN-1:0]  statusReg,
  output logic [2:0]       dbSel
);
  localparam int POL_LSB = 16;

  logic [NPIN-1:0] syncA;
  logic [NPIN-1:0] pinEn;
  logic [NPIN-1:0] pinPol;
  logic [NPIN-1:0] pinHit;
  logic [NSRC-1:0] srcEn;
  logic            alarmHit;
  logic            alarmHitQ;
  logic [CNT_W-1:0] period;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      pinSync <= '0;
    end else begin
      syncA   <= pinsIn;
      pinSync <= syncA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinEn  <= '0;
      pinPol <= '0;
      dbSel  <= '0;
      srcEn  <= '0;
    end else begin
      if (strb.wrPinCfg) begin
        pinEn  <= wdata[NPIN-1:0];
        pinPol <= wdata[POL_LSB +: NPIN];
      end
      if (strb.wrMode) begin
        dbSel <= wdata[2:0];
        srcEn <= wdata[8 +: NSRC];
      end
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_qual
    assign pinHit[i] = pinEn[i] & (pinSync[i] == pinPol[i]);
  end

  assign trigger = |pinHit;
  assign period  = debounce_period(dbSel);
  assign dbFire  = trigger && (dbCount == period);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbCount <= '0;
    end else if (!trigger) begin
      dbCount <= '0;
    end else if (dbCount <= period) begin
      dbCount <= dbCount + 1'b1;
    end
  end

  assign alarmHit = |(srcEn & srcIn);
  assign alarmEvt = alarmHit & ~alarmHitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) alarmHitQ <= 1'b0;
    else       alarmHitQ <= alarmHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               statusReg <= '0;
    else if (strb.capStatus) statusReg <= pinSync;
    else if (strb.clrStatus) statusReg <= '0;
  end

  always_comb begin
    rdData = '0;
    case (reg_addr_e'(rdAddr))
      ADDR_PINCFG: begin
        rdData[NPIN-1:0]           = pinEn;
        rdData[POL_LSB +: NPIN]    = pinPol;
      end
      ADDR_MODE: begin
        rdData[2:0]        = dbSel;
        rdData[8 +: NSRC]  = srcEn;
      end
      ADDR_STATUS: rdData[NPIN-1:0] = statusReg;
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/wake_control.sv
module wake_control
  import wake_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [1:0] regAddr,
  input  logic       dbFire,
  input  logic       alarmEvt,
  input  logic       wakeAck,
  output strobe_t    strb,
  output logic       wakeReq
);
  logic wakeEvt;

  assign wakeEvt = dbFire | alarmEvt;

  always_comb begin
    strb.wrPinCfg  = regWrEn && (reg_addr_e'(regAddr) == ADDR_PINCFG);
    strb.wrMode    = regWrEn && (reg_addr_e'(regAddr) == ADDR_MODE);
    strb.clrStatus = regRdEn && (reg_addr_e'(regAddr) == ADDR_STATUS);
    strb.capStatus = wakeEvt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        wakeReq <= 1'b0;
    else if (wakeEvt) wakeReq <= 1'b1;
    else if (wakeAck) wakeReq <= 1'b0;
  end
endmodule

// File: rtl/wake_debounce_ctrl.sv
module wake_debounce_ctrl
  import wake_ctrl_pkg::*;
#(
  parameter int NPIN = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NPIN-1:0] wakePins,
  input  logic            calAlarm,
  input  logic            tmrAlarm,
  input  logic            supMon,
  input  logic            regWrEn,
  input  logic            regRdEn,
  input  logic [1:0]      regAddr,
  input  logic [31:0]     regWdata,
  output logic [31:0]     regRdata,
  input  logic            wakeAck,
  output logic            wakeReq
);
  strobe_t          strb;
  logic             trigger;
  logic [CNT_W-1:0] dbCount;
  logic             dbFire;
  logic             alarmEvt;
  logic [NPIN-1:0]  pinSync;
  logic [NPIN-1:0]  statusReg;
  logic [2:0]       dbSel;

  wake_control u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .dbFire(dbFire), .alarmEvt(alarmEvt),
    .wakeAck(wakeAck), .strb(strb), .wakeReq(wakeReq)
  );

  wake_datapath #(.NPIN(NPIN)) u_dp (
    .clk(clk), .rstN(rstN), .pinsIn(wakePins),
    .srcIn({supMon, tmrAlarm, calAlarm}), .strb(strb), .wdata(regWdata),
    .rdAddr(regAddr), .rdData(regRdata), .trigger(trigger),
    .dbCount(dbCount), .dbFire(dbFire), .alarmEvt(alarmEvt),
    .pinSync(pinSync), .statusReg(statusReg), .dbSel(dbSel)
  );
endmodule

// File: rtl/wake_ctrl_checker.sv
module wake_ctrl_checker
  import wake_ctrl_pkg::*;
#(
  parameter int NPIN = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wakeReq,
  input logic             wakeAck,
  input logic             trigger,
  input logic [CNT_W-1:0] dbCount,
  input logic             dbFire,
  input logic             alarmEvt,
  input logic [NPIN-1:0]  pinSync,
  input logic [NPIN-1:0]  statusReg,
  input logic [2:0]       dbSel,
  input strobe_t          strb
);
  p_fire_needs_trigger_r5: assert property (@(posedge clk) disable iff (!rstN)
    dbFire |-> trigger);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    dbCount <= CNT_W'(LONGEST_PERIOD + 1));

  p_count_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    !trigger |=> (dbCount == '0));

  p_immediate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dbSel == 3'd0 && trigger && !$past(trigger)) |-> dbFire);

  p_capture_r8: assert property (@(posedge clk) disable iff (!rstN)
    dbFire |=> (statusReg == $past(pinSync)));

  p_read_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrStatus && !dbFire && !alarmEvt) |=> (statusReg == '0));

  p_req_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dbFire || alarmEvt) |=> wakeReq);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReq && !wakeAck) |=> wakeReq);

  p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wakeAck && !dbFire && !alarmEvt) |=> !wakeReq);
endmodule

bind wake_debounce_ctrl wake_ctrl_checker #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rstN(rstN), .wakeReq(wakeReq), .wakeAck(wakeAck),
  .trigger(trigger), .dbCount(dbCount), .dbFire(dbFire),
  .alarmEvt(alarmEvt), .pinSync(pinSync), .statusReg(statusReg),
  .dbSel(dbSel), .strb(strb)
);

// File: tb/wake_debounce_ctrl_bench.sv
`timescale 1ns/1ps
module wake_debounce_ctrl_bench;
  localparam int NPIN = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NPIN-1:0] wakePins = '0;
  logic            calAlarm = 1'b0;
  logic            tmrAlarm = 1'b0;
  logic            supMon = 1'b0;
  logic            regWrEn = 1'b0;
  logic            regRdEn = 1'b0;
  logic [1:0]      regAddr = '0;
  logic [31:0]     regWdata = '0;
  logic [31:0]     regRdata;
  logic            wakeAck = 1'b0;
  logic            wakeReq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wake_debounce_ctrl #(.NPIN(NPIN)) u_wake_debounce_ctrl (
    .clk(clk), .rstN(rstN), .wakePins(wakePins), .calAlarm(calAlarm),
    .tmrAlarm(tmrAlarm), .supMon(supMon), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .wakeAck(wakeAck), .wakeReq(wakeReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    wakeAck = 1'b1;
    @(negedge clk);
    wakeAck = 1'b0;
  endtask

  task automatic cleanup();
    logic [31:0] d;
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    wakePins = '0; calAlarm = 1'b0; tmrAlarm = 1'b0; supMon = 1'b0;
    tick(5);
    ack();
    rd(2'd2, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 wakeReq after reset", {31'b0, wakeReq}, 32'h0);
    rd(2'd0, d); chk("R1 pin cfg reset", d, 32'h0);
    rd(2'd1, d); chk("R1 mode reset", d, 32'h0);
    rd(2'd2, d); chk("R1 status reset", d, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(2'd0, 32'hA5A5_1234);
    rd(2'd0, d); chk("R2 pin cfg readback", d, 32'hA5A5_1234);
    wr(2'd1, 32'hFFFF_FFFD);
    rd(2'd1, d); chk("R2 mode readback masks unused", d, 32'h0000_0705);
    rd(2'd3, d); chk("R2 address 3 reads zero", d, 32'h0);
    cleanup();
  endtask

  task automatic t_immediate();
    logic [31:0] d;
    wr(2'd0, 32'h0004_0004);
    wr(2'd1, 32'h0);
    @(negedge clk); wakePins[2] = 1'b1;
    tick(2); chk("R5 no request before edge P+3", {31'b0, wakeReq}, 32'h0);
    tick(1); chk("R7 immediate wake on edge 3", {31'b0, wakeReq}, 32'h1);
    wakePins[2] = 1'b0;
    tick(3);
    rd(2'd2, d); chk("R8 status captured pin 2", d, 32'h4);
    rd(2'd2, d); chk("R8 status cleared by read", d, 32'h0);
    ack(); chk("R11 ack clears request", {31'b0, wakeReq}, 32'h0);
    // single-cycle pulse in immediate mode
    @(negedge clk); wakePins[2] = 1'b1;
    @(negedge clk); wakePins[2] = 1'b0;
    tick(4); chk("R7 one-cycle pulse wakes", {31'b0, wakeReq}, 32'h1);
    cleanup();
  endtask

  task automatic t_sel1_boundary();
    wr(2'd0, 32'h0004_0004);
    wr(2'd1, 32'h1);
    @(negedge clk); wakePins[2] = 1'b1;
    tick(3); wakePins[2] = 1'b0;
    tick(8); chk("R5 pulse of P=3 cycles ignored", {31'b0, wakeReq}, 32'h0);
    wakePins[2] = 1'b1;
    tick(5); chk("R4 no request at edge P+2", {31'b0, wakeReq}, 32'h0);
    tick(1); chk("R4 select 1 fires at edge P+3", {31'b0, wakeReq}, 32'h1);
    cleanup();
  endtask

  task automatic t_drop();
    wr(2'd0, 32'h0004_0004);
    wr(2'd1, 32'h1);
    @(negedge clk); wakePins[2] = 1'b1;
    tick(3); wakePins[2] = 1'b0;
    tick(1); wakePins[2] = 1'b1;
    tick(3); wakePins[2] = 1'b0;
    tick(8); chk("R6 gap restarts count", {31'b0, wakeReq}, 32'h0);
    cleanup();
  endtask

  task automatic t_polarity();
    @(negedge clk); wakePins[5] = 1'b1;
    wr(2'd0, 32'h0000_0020);
    wr(2'd1, 32'h0);
    @(negedge clk); wakePins[7] = 1'b1;
    tick(6); chk("R3 disabled pin ignored", {31'b0, wakeReq}, 32'h0);
    wakePins[5] = 1'b0;
    tick(2); chk("R3 low-active not yet", {31'b0, wakeReq}, 32'h0);
    tick(1); chk("R3 low-active pin wakes", {31'b0, wakeReq}, 32'h1);
    cleanup();
  endtask

  task automatic t_overwrite();
    logic [31:0] d;
    wr(2'd0, 32'h0208_0208);
    wr(2'd1, 32'h0);
    @(negedge clk); wakePins[3] = 1'b1;
    tick(4); wakePins[3] = 1'b0;
    ack();
    wakePins[9] = 1'b1;
    tick(4);
    rd(2'd2, d); chk("R9 later wake overwrites status", d, 32'h200);
    cleanup();
  endtask

  task automatic t_capture_wins();
    logic [31:0] d;
    wr(2'd0, 32'h0010_0010);
    wr(2'd1, 32'h0);
    @(negedge clk); wakePins[4] = 1'b1;
    tick(2);
    regRdEn = 1'b1; regAddr = 2'd2;
    @(negedge clk); regRdEn = 1'b0;
    rd(2'd2, d); chk("R8 capture beats same-cycle clear", d, 32'h10);
    cleanup();
  endtask

  task automatic t_alarms();
    wr(2'd1, 32'h0000_0100);
    @(negedge clk); tmrAlarm = 1'b1;
    tick(3); chk("R10 disabled timer alarm ignored", {31'b0, wakeReq}, 32'h0);
    calAlarm = 1'b1;
    tick(1); chk("R10 calendar alarm wakes next edge", {31'b0, wakeReq}, 32'h1);
    tick(3); chk("R11 request held without ack", {31'b0, wakeReq}, 32'h1);
    ack(); chk("R11 ack clears while level held", {31'b0, wakeReq}, 32'h0);
    calAlarm = 1'b0;
    tick(2);
    calAlarm = 1'b1; wakeAck = 1'b1;
    tick(1); wakeAck = 1'b0;
    chk("R11 event wins over ack", {31'b0, wakeReq}, 32'h1);
    cleanup();
    wr(2'd1, 32'h0000_0400);
    @(negedge clk); supMon = 1'b1;
    tick(1); chk("R10 supply monitor wakes", {31'b0, wakeReq}, 32'h1);
    cleanup();
  endtask

  task automatic t_long(input logic [2:0] sel, input int p, input string tag);
    wr(2'd0, 32'h0001_0001);
    wr(2'd1, {29'b0, sel});
    @(negedge clk); wakePins[0] = 1'b1;
    tick(p + 2); chk({tag, " quiet at edge P+2"}, {31'b0, wakeReq}, 32'h0);
    tick(1);     chk({tag, " fires at edge P+3"}, {31'b0, wakeReq}, 32'h1);
    cleanup();
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    t_reset();
    t_regs();
    t_immediate();
    t_sel1_boundary();
    t_drop();
    t_polarity();
    t_overwrite();
    t_capture_wins();
    t_alarms();
    t_long(3'd2, 32, "R4 select 2");
    t_long(3'd7, 32768, "R4 select 7");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule